// File: doc/BRIEF.md
# Receive Character Buffer with Error Tracking

This block sits between the receive shift register of an asynchronous serial channel and the host register interface. Every assembled character arrives as a one-cycle parallel strobe. Three error flags travel with it: line break seen, framing error and parity error. The character and its flags are stored together in a small first-in first-out queue of `DEPTH` entries (three by default). The host takes characters out with a read strobe, and the last character read stays on `rd_data`.

A composite status byte reports the error flags, the sticky overrun flag, two transmitter indications passed through from the neighbouring transmitter, the full flag and the ready flag. A mode input sets how the error flags behave:
- **Per-character mode:** the status shows the flags of the character at the head of the queue.
- **Block mode:** the status shows the OR of the flags of every character accepted since the last clear.

A second mode input selects whether the interrupt follows "at least one character held" or "queue full". An error-clear command clears the overrun flag and the block accumulator. A receiver-flush command empties the queue and clears all flags.

Top module: `rx_char_buffer`

## Requirements
- R1: The queue holds up to `DEPTH` (3) characters in arrival order. `rx_ready` (status bit 0) is high while at least one character is held. `rx_full` (status bit 1) is high exactly when `DEPTH` characters are held.
- R2: A `rd_strobe` cycle with a non-empty queue removes the head character. From the next cycle `rd_data` shows that character until the next successful read.
- R3: A `rd_strobe` cycle with an empty queue leaves `rd_data`, `rx_ready`, `rx_full`, `overrun` and the status flags unchanged.
- R4: A character that arrives while the queue is full and no read is made in that cycle is dropped. The stored entries are kept, and `overrun` (status bit 4) is set from the next cycle and stays set until a clear.
- R5: A character arrival and a successful read in the same cycle leave the occupancy unchanged. When the queue is full, the arriving character is accepted and `rx_full` stays high with no gap.
- R6: Status bit 7 is break, bit 6 is framing error and bit 5 is parity error. In per-character mode (`blk_mode`=0) these bits are the flags of the head character, or zero when the queue is empty, so a character's flags leave with it when it is read.
- R7: In block mode (`blk_mode`=1), status bits 7:5 are the OR of the flags of all accepted characters since the last clear, and reads do not clear them.
- R8: An `err_clr` cycle clears `overrun` and the block accumulator from the next cycle and leaves the queue contents alone. A character or overflow in that same cycle counts as arriving after the clear.
- R9: A `rx_flush` cycle empties the queue, clears `overrun` and all error flags, and drops `rx_ready` and `rx_full` in the next cycle. A character arriving in that cycle is discarded, and `rd_data` keeps its value.
- R10: `rx_irq` follows `rx_ready` when `irq_on_full`=0 and follows `rx_full` when `irq_on_full`=1.
- R11: Status bit 3 equals `tx_empty` and status bit 2 equals `tx_ready`.
- R12: After a cycle with `rst` high (synchronous, active high), the queue is empty, all flags are clear and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | A new character is presented this cycle |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break flag of the character |
| rx_frm | input | 1 | Framing error flag of the character |
| rx_par | input | 1 | Parity error flag of the character |
| tx_empty | input | 1 | Transmitter empty, shown in status bit 3 |
| tx_ready | input | 1 | Transmitter ready, shown in status bit 2 |
| blk_mode | input | 1 | 1 = block (cumulative) error mode |
| irq_on_full | input | 1 | 1 = interrupt on full, 0 = on ready |
| rd_strobe | input | 1 | Host reads the data register |
| err_clr | input | 1 | Error-clear command |
| rx_flush | input | 1 | Receiver-flush command |
| rd_data | output | 8 | Last character read |
| status | output | 8 | Composite status byte |
| rx_ready | output | 1 | At least one character held |
| rx_full | output | 1 | Queue full |
| overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bound checker watches these rules on every cycle:
- full implies ready;
- the overrun and block flags stay set;
- overflow, error-clear and flush have their next-cycle effects;
- a read at full with a simultaneous arrival keeps the queue full;
- an empty read leaves `rd_data` alone;
- the interrupt selection holds.

Only the bench's scenarios can show the ordering of data through the queue and which flags belong to which head character. They also show that the character at full with a read is really stored, and that the character dropped on overflow or flush never appears.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int DATA_W   = 8;
    localparam int STAT_W   = 8;

    // status byte bit positions (decoded by the host register interface)
    localparam int ST_BRK   = 7;
    localparam int ST_FRM   = 6;
    localparam int ST_PAR   = 5;
    localparam int ST_OVR   = 4;
    localparam int ST_TXE   = 3;
    localparam int ST_TXR   = 2;
    localparam int ST_FULL  = 1;
    localparam int ST_RDY   = 0;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxb_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rxb_flags_t        flags;
    } rxb_entry_t;

    typedef enum logic {
        IRQ_ON_READY = 1'b0,
        IRQ_ON_FULL  = 1'b1
    } rxb_irq_sel_t;

    function automatic rxb_flags_t flags_or(input rxb_flags_t a, input rxb_flags_t b);
        rxb_flags_t r;
        r.brk = a.brk | b.brk;
        r.frm = a.frm | b.frm;
        r.par = a.par | b.par;
        return r;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(
        input rxb_flags_t f,
        input logic       ovr,
        input logic       txe,
        input logic       txr,
        input logic       full,
        input logic       rdy
    );
        logic [STAT_W-1:0] s;
        s           = '0;
        s[ST_BRK]   = f.brk;
        s[ST_FRM]   = f.frm;
        s[ST_PAR]   = f.par;
        s[ST_OVR]   = ovr;
        s[ST_TXE]   = txe;
        s[ST_TXR]   = txr;
        s[ST_FULL]  = full;
        s[ST_RDY]   = rdy;
        return s;
    endfunction

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  rxb_entry_t        wr_entry,
    input  logic              pop,
    output rxb_entry_t        head,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              full,
    output logic              accepted,
    output logic              dropped
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    rxb_entry_t        slot_view [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop_ok;
    logic              push_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok   = pop && !flush && (count != '0);
    assign push_ok  = push && !flush && ((count != CNT_FULL) || pop_ok);
    assign accepted = push_ok;
    assign dropped  = push && !flush && !push_ok;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rxb_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == PTR_W'(i))) begin
                slot_q <= wr_entry;
            end
        end
        assign slot_view[i] = slot_q;
    end

    assign head      = slot_view[rd_ptr];
    assign not_empty = (count != '0);
    assign full      = (count == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            if (push_ok) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (pop_ok) begin
            rd_data <= head.data;
        end
    end

endmodule

// File: rtl/rxb_errtrack.sv
module rxb_errtrack
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       clr,
    input  logic       accept,
    input  rxb_flags_t new_flags,
    input  logic       overflow,
    output rxb_flags_t acc_flags,
    output logic       ovr
);

    rxb_flags_t acc_q;
    rxb_flags_t base;
    rxb_flags_t incoming;
    logic       ovr_q;

    always_comb begin
        base     = clr    ? rxb_flags_t'('0) : acc_q;
        incoming = accept ? new_flags        : rxb_flags_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            acc_q <= flags_or(base, incoming);
            ovr_q <= (ovr_q && !clr) || overflow;
        end
    end

    assign acc_flags = acc_q;
    assign ovr       = ovr_q;

endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import rxb_pkg::*;
(
    input  logic              blk_mode,
    input  rxb_irq_sel_t      irq_sel,
    input  rxb_entry_t        head,
    input  logic              not_empty,
    input  logic              full,
    input  rxb_flags_t        acc_flags,
    input  logic              ovr,
    input  logic              tx_empty,
    input  logic              tx_ready,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    rxb_flags_t shown;

    always_comb begin
        if (blk_mode) begin
            shown = acc_flags;
        end else if (not_empty) begin
            shown = head.flags;
        end else begin
            shown = '0;
        end
        status = pack_status(shown, ovr, tx_empty, tx_ready, full, not_empty);
        irq    = (irq_sel == IRQ_ON_FULL) ? full : not_empty;
    end

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_brk,
    input  logic              rx_frm,
    input  logic              rx_par,
    input  logic              tx_empty,
    input  logic              tx_ready,
    input  logic              blk_mode,
    input  logic              irq_on_full,
    input  logic              rd_strobe,
    input  logic              err_clr,
    input  logic              rx_flush,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] status,
    output logic              rx_ready,
    output logic              rx_full,
    output logic              overrun,
    output logic              rx_irq
);

    rxb_entry_t in_entry;
    rxb_entry_t head;
    rxb_flags_t acc_flags;
    logic       not_empty;
    logic       full;
    logic       accepted;
    logic       dropped;
    logic       ovr;

    assign in_entry.data      = rx_char;
    assign in_entry.flags.brk = rx_brk;
    assign in_entry.flags.frm = rx_frm;
    assign in_entry.flags.par = rx_par;

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (rx_strobe),
        .wr_entry  (in_entry),
        .pop       (rd_strobe),
        .head      (head),
        .rd_data   (rd_data),
        .not_empty (not_empty),
        .full      (full),
        .accepted  (accepted),
        .dropped   (dropped)
    );

    rxb_errtrack u_err (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .clr       (err_clr),
        .accept    (accepted),
        .new_flags (in_entry.flags),
        .overflow  (dropped),
        .acc_flags (acc_flags),
        .ovr       (ovr)
    );

    rxb_status u_stat (
        .blk_mode  (blk_mode),
        .irq_sel   (rxb_irq_sel_t'(irq_on_full)),
        .head      (head),
        .not_empty (not_empty),
        .full      (full),
        .acc_flags (acc_flags),
        .ovr       (ovr),
        .tx_empty  (tx_empty),
        .tx_ready  (tx_ready),
        .status    (status),
        .irq       (rx_irq)
    );

    assign rx_ready = not_empty;
    assign rx_full  = full;
    assign overrun  = ovr;

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_strobe,
    input logic       blk_mode,
    input logic       irq_on_full,
    input logic       rd_strobe,
    input logic       err_clr,
    input logic       rx_flush,
    input logic [7:0] rd_data,
    input logic [7:0] status,
    input logic       rx_ready,
    input logic       rx_full,
    input logic       overrun,
    input logic       rx_irq
);

    a_r1_full_has_data: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_ready);

    a_r3_empty_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && rd_strobe) |=> $stable(rd_data));

    a_r4_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_strobe && !rd_strobe && !rx_flush) |=> (overrun && rx_full));

    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !err_clr && !rx_flush) |=> overrun);

    a_r5_full_swap: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_strobe && rd_strobe && !rx_flush) |=> rx_full);

    a_r7_block_sticky: assert property (@(posedge clk) disable iff (rst)
        (blk_mode && status[7] && !err_clr && !rx_flush) |=> (!blk_mode || status[7]));

    a_r8_clear_overrun: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !rx_flush && !(rx_full && rx_strobe && !rd_strobe)) |=> !overrun);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (!rx_ready && !rx_full && !overrun && (status[7:5] == 3'b000)));

    a_r10_irq_ready: assert property (@(posedge clk) disable iff (rst)
        (!irq_on_full && rx_ready) |-> rx_irq);

    a_r10_irq_full: assert property (@(posedge clk) disable iff (rst)
        (irq_on_full && !rx_full) |-> !rx_irq);

endmodule

bind rx_char_buffer rxb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_strobe   (rx_strobe),
    .blk_mode    (blk_mode),
    .irq_on_full (irq_on_full),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .rx_flush    (rx_flush),
    .rd_data     (rd_data),
    .status      (status),
    .rx_ready    (rx_ready),
    .rx_full     (rx_full),
    .overrun     (overrun),
    .rx_irq      (rx_irq)
);

// File: tb/rx_char_buffer_bench.sv
`timescale 1ns/1ps
module rx_char_buffer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_strobe, rx_brk, rx_frm, rx_par;
    logic [7:0] rx_char;
    logic       tx_empty, tx_ready, blk_mode, irq_on_full;
    logic       rd_strobe, err_clr, rx_flush;
    logic [7:0] rd_data, status;
    logic       rx_ready, rx_full, overrun, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rx_char_buffer u_rx_char_buffer (
        .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_char(rx_char),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par),
        .tx_empty(tx_empty), .tx_ready(tx_ready), .blk_mode(blk_mode),
        .irq_on_full(irq_on_full), .rd_strobe(rd_strobe), .err_clr(err_clr),
        .rx_flush(rx_flush), .rd_data(rd_data), .status(status),
        .rx_ready(rx_ready), .rx_full(rx_full), .overrun(overrun), .rx_irq(rx_irq)
    );

    // vector: strobe, char, flags{brk,frm,par}, read | exp ready, full, ovr, status[7:5], rd_data
    localparam int NVEC = 9;
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b1, 8'hA1, 3'b000, 1'b0,  1'b1, 1'b0, 1'b0, 3'b000, 8'h00},
        {1'b1, 8'hB2, 3'b010, 1'b0,  1'b1, 1'b0, 1'b0, 3'b000, 8'h00},
        {1'b1, 8'hC3, 3'b001, 1'b0,  1'b1, 1'b1, 1'b0, 3'b000, 8'h00},
        {1'b1, 8'hD4, 3'b100, 1'b0,  1'b1, 1'b1, 1'b1, 3'b000, 8'h00},
        {1'b0, 8'h00, 3'b000, 1'b1,  1'b1, 1'b0, 1'b1, 3'b010, 8'hA1},
        {1'b1, 8'hE5, 3'b000, 1'b1,  1'b1, 1'b0, 1'b1, 3'b001, 8'hB2},
        {1'b0, 8'h00, 3'b000, 1'b1,  1'b1, 1'b0, 1'b1, 3'b000, 8'hC3},
        {1'b0, 8'h00, 3'b000, 1'b1,  1'b0, 1'b0, 1'b1, 3'b000, 8'hE5},
        {1'b0, 8'h00, 3'b000, 1'b1,  1'b0, 1'b0, 1'b1, 3'b000, 8'hE5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [7:0] d, input logic [2:0] f,
                       input logic rd, input logic ec, input logic fl);
        @(negedge clk);
        rx_strobe = v;
        rx_char   = d;
        {rx_brk, rx_frm, rx_par} = f;
        rd_strobe = rd;
        err_clr   = ec;
        rx_flush  = fl;
        @(posedge clk);
        #1;
        rx_strobe = 1'b0;
        rd_strobe = 1'b0;
        err_clr   = 1'b0;
        rx_flush  = 1'b0;
        {rx_brk, rx_frm, rx_par} = 3'b000;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f);
        cyc(1'b1, d, f, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0);
        chk(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    initial begin
        rst = 1'b1; rx_strobe = 0; rx_char = 0; rx_brk = 0; rx_frm = 0; rx_par = 0;
        tx_empty = 0; tx_ready = 0; blk_mode = 0; irq_on_full = 0;
        rd_strobe = 0; err_clr = 0; rx_flush = 0;
        repeat (2) @(posedge clk);
        #1;
        // R12 reset state
        chk("R12 reset state", {13'h0, rx_ready, rx_full, overrun, rx_irq, status, rd_data}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        // R11 transmitter pass-through
        tx_empty = 1'b1; tx_ready = 1'b0;
        #1;
        chk("R11 tx bits 10", {30'h0, status[3:2]}, 32'h2);
        tx_empty = 1'b0; tx_ready = 1'b1;
        #1;
        chk("R11 tx bits 01", {30'h0, status[3:2]}, 32'h1);
        tx_ready = 1'b0;

        // vector walk: R1 R2 R3 R4 R5 R6 in per-character mode
        for (int i = 0; i < NVEC; i++) begin
            logic [26:0] v;
            v = VEC[i];
            cyc(v[26], v[25:18], v[17:15], v[14], 1'b0, 1'b0);
            chk($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", i),
                {18'h0, rx_ready, rx_full, overrun, status[7:5], rd_data},
                {18'h0, v[13:0]});
        end

        // R9 flush also clears the overrun left by the vectors
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
        chk("R9 flush clears overrun", {31'h0, overrun}, 32'h0);

        // R10 interrupt selection
        push(8'h11, 3'b000);
        chk("R10 irq on ready", {31'h0, rx_irq}, 32'h1);
        irq_on_full = 1'b1;
        #1;
        chk("R10 irq on full, not full", {31'h0, rx_irq}, 32'h0);
        push(8'h22, 3'b000);
        push(8'h33, 3'b000);
        chk("R10 irq on full, full", {30'h0, rx_irq, rx_full}, 32'h3);

        // R5 arrival and read at full
        cyc(1'b1, 8'h44, 3'b000, 1'b1, 1'b0, 1'b0);
        chk("R5 full kept on swap", {23'h0, rx_full, overrun, rd_data}, {23'h0, 1'b1, 1'b0, 8'h11});
        pop_expect("R5 order 22", 8'h22);
        pop_expect("R5 order 33", 8'h33);
        pop_expect("R5 swapped char stored", 8'h44);
        chk("R1 empty after drain", {30'h0, rx_ready, rx_full}, 32'h0);

        // R9 flush with a full queue and a character in the same cycle
        push(8'h55, 3'b100);
        push(8'h66, 3'b000);
        push(8'h77, 3'b000);
        push(8'h88, 3'b000);
        chk("R4 overflow set", {30'h0, overrun, rx_full}, 32'h3);
        cyc(1'b1, 8'h99, 3'b111, 1'b0, 1'b0, 1'b1);
        chk("R9 flush state", {21'h0, rx_ready, rx_full, overrun, status[7:5], rd_data},
            {21'h0, 3'b000, 3'b000, 8'h44});
        cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0);
        chk("R9 flushed char absent", {23'h0, rx_ready, rd_data}, {23'h0, 1'b0, 8'h44});

        // R7 block mode accumulation
        blk_mode = 1'b1;
        push(8'h01, 3'b100);
        push(8'h02, 3'b001);
        chk("R7 block OR", {29'h0, status[7:5]}, 32'h5);
        pop_expect("R7 read 01", 8'h01);
        pop_expect("R7 read 02", 8'h02);
        chk("R7 flags survive reads", {28'h0, rx_ready, status[7:5]}, 32'h5);

        // R8 error clear with a character in the same cycle
        cyc(1'b1, 8'h03, 3'b010, 1'b0, 1'b1, 1'b0);
        chk("R8 clear then new flags", {28'h0, overrun, status[7:5]}, 32'h2);
        push(8'h04, 3'b000);
        push(8'h05, 3'b000);
        push(8'h06, 3'b000);
        chk("R4 overflow in block mode", {31'h0, overrun}, 32'h1);
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
        chk("R8 clear keeps queue", {27'h0, overrun, rx_full, status[7:5]}, 32'h8);
        pop_expect("R8 head intact", 8'h03);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule